// File: doc/BRIEF.md
# Circular DMA Segment Write-Pointer Manager

This block keeps the write pointer of one DMA stream that fills a circular segment inside a larger buffer region. Software programs the segment bounds, a limit offset and an interrupt threshold through a small register-style write port. All offsets are byte offsets from the base of the global buffer. The end offset is the first byte past the segment.

The burst scheduler reads the current pointer as its next destination offset. It also reads how many 8-byte beats it may write. That count stops at the segment end, at a limit ahead of the pointer, and at 16 beats. When the pointer sits on the limit, the block stalls the writer until software moves the limit. The scheduler reports each completed transfer with its beat count, and the pointer then moves forward. A pointer that lands on the segment end wraps straight back to the start.

A progress interrupt goes pending when an advance crosses or lands on the threshold offset, wraparound included, but only while the stream interrupt is enabled. The interrupt output also needs a global enable.

Top module: `dma_ring_ptr`

## Requirements
- R1: After reset the pointer, all configured offsets, the stream interrupt enable and the pending flag are zero. Because the pointer equals the limit, `stall` is 1 and `avail_beats` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the field chosen by `cfg_sel`. The codes are 0 for start, 1 for end and 2 for limit, each with the low 7 bits forced to zero. Code 3 is the threshold, with the low 3 bits forced to zero. Code 4 is interrupt control and code 5 is reinitialize. Codes 6 and 7 change nothing.
- R3: A reinitialize write loads the pointer with the start offset and takes priority over a completion in the same cycle. Apart from these two events the pointer holds its value.
- R4: On `xfer_done` the pointer advances by 8 × `xfer_beats` bytes. If the result equals or passes the end offset, the pointer becomes the start offset in that same update.
- R5: `avail_beats` is the smallest of three values: 16, the number of words to the end offset, and the number of words to the limit when the limit lies above the pointer. A limit below the pointer does not restrict it.
- R6: When the pointer equals the limit, `stall` is 1 and `avail_beats` is 0. Writing a different limit releases the stall.
- R7: A completion sets `irq_pending` when the stream enable is 1 and either of two cases holds. In the first, the threshold T satisfies old pointer < T ≤ old pointer + bytes. In the second, the advance wraps and T equals the start offset. With the enable at 0 the pending flag stays clear.
- R8: An interrupt-control write (code 4) sets the stream enable to `cfg_wdata[0]` and clears `irq_pending`. The clear wins over a threshold hit in the same cycle.
- R9: `irq` is 1 exactly when `irq_pending` and `glb_irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | OFS_W | Configuration write data (byte offset or control bits) |
| glb_irq_en | input | 1 | Global interrupt enable |
| xfer_done | input | 1 | A transfer to the current pointer completed |
| xfer_beats | input | BW | Beats in the completed transfer |
| wr_ptr | output | OFS_W | Current write pointer, byte offset |
| avail_beats | output | BW | Beats the scheduler may write next |
| stall | output | 1 | Pointer sits on the limit |
| irq_pending | output | 1 | Stream interrupt pending |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach is a threshold hit that comes only from wraparound. The advance must end exactly on the segment end while the threshold equals the start offset, so that no plain crossing hides the wrap path. The stimulus moves the limit behind the pointer so the whole tail is available. It writes a 16-beat burst and then a 15-beat burst that lands on the end. The bench also drives an interrupt-control write and a threshold-hitting completion in the same cycle to check which one wins.

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr #(
  parameter int OFS_W     = 20,
  parameter int MAX_BURST = 16,
  parameter int BW        = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [OFS_W-1:0] cfg_wdata,
  input  logic             glb_irq_en,
  input  logic             xfer_done,
  input  logic [BW-1:0]    xfer_beats,
  output logic [OFS_W-1:0] wr_ptr,
  output logic [BW-1:0]    avail_beats,
  output logic             stall,
  output logic             irq_pending,
  output logic             irq
);
  localparam logic [2:0] SEL_START = 3'd0, SEL_END = 3'd1, SEL_LIMIT = 3'd2,
                         SEL_THR = 3'd3, SEL_CTRL = 3'd4, SEL_REINIT = 3'd5;
  localparam logic [OFS_W-1:0] MASK_SEG  = {{(OFS_W-7){1'b1}}, 7'b0};
  localparam logic [OFS_W-1:0] MASK_WORD = {{(OFS_W-3){1'b1}}, 3'b0};

  logic [OFS_W-1:0] start_q, end_q, lim_q, thr_q, ptr_q;
  logic             en_q, pend_q;

  logic [OFS_W-1:0] to_end, to_lim, room, room_w, step, sum, nxt;
  logic             lim_ahead, wrap, hit, do_ctrl, do_reinit;

  assign to_end    = end_q - ptr_q;
  assign to_lim    = lim_q - ptr_q;
  assign lim_ahead = lim_q > ptr_q;
  assign room      = (lim_ahead && to_lim < to_end) ? to_lim : to_end;
  assign room_w    = room >> 3;

  always_comb begin
    if (lim_q == ptr_q)                         avail_beats = '0;
    else if (room_w >= OFS_W'(MAX_BURST))       avail_beats = BW'(MAX_BURST);
    else                                        avail_beats = room_w[BW-1:0];
  end

  assign step = OFS_W'({xfer_beats, 3'b000});
  assign sum  = ptr_q + step;
  assign wrap = sum >= end_q;
  assign nxt  = wrap ? start_q : sum;
  assign hit  = (thr_q > ptr_q && thr_q <= sum) || (wrap && thr_q == start_q);

  assign do_ctrl   = cfg_we && cfg_sel == SEL_CTRL;
  assign do_reinit = cfg_we && cfg_sel == SEL_REINIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0; end_q <= '0; lim_q <= '0; thr_q <= '0;
      ptr_q   <= '0; en_q  <= 1'b0; pend_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_START: start_q <= cfg_wdata & MASK_SEG;
          SEL_END:   end_q   <= cfg_wdata & MASK_SEG;
          SEL_LIMIT: lim_q   <= cfg_wdata & MASK_SEG;
          SEL_THR:   thr_q   <= cfg_wdata & MASK_WORD;
          SEL_CTRL:  en_q    <= cfg_wdata[0];
          default:   ;
        endcase
      end
      if (do_reinit)      ptr_q <= start_q;
      else if (xfer_done) ptr_q <= nxt;
      if (do_ctrl)                         pend_q <= 1'b0;
      else if (xfer_done && hit && en_q)   pend_q <= 1'b1;
    end
  end

  assign wr_ptr      = ptr_q;
  assign stall       = lim_q == ptr_q;
  assign irq_pending = pend_q;
  assign irq         = pend_q & glb_irq_en;

  p_no_grant_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> avail_beats == '0);
  p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    avail_beats <= BW'(MAX_BURST));
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done && !do_reinit) |=> $stable(wr_ptr));
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_ctrl |=> !irq_pending);
  p_beats_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> xfer_beats <= avail_beats);
endmodule

// File: tb/dma_ring_ptr_tb.sv
`timescale 1ns/1ps
module dma_ring_ptr_tb_top;
  localparam int OFS_W = 20;
  localparam int BW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_sel = '0;
  logic [OFS_W-1:0] cfg_wdata = '0;
  logic             glb_irq_en = 1'b0;
  logic             xfer_done = 1'b0;
  logic [BW-1:0]    xfer_beats = '0;
  logic [OFS_W-1:0] wr_ptr;
  logic [BW-1:0]    avail_beats;
  logic             stall, irq_pending, irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dma_ring_ptr #(.OFS_W(OFS_W), .MAX_BURST(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .glb_irq_en(glb_irq_en), .xfer_done(xfer_done),
    .xfer_beats(xfer_beats), .wr_ptr(wr_ptr), .avail_beats(avail_beats),
    .stall(stall), .irq_pending(irq_pending), .irq(irq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = OFS_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input int beats);
    @(negedge clk);
    xfer_done = 1'b1; xfer_beats = BW'(beats);
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "ptr", int'(wr_ptr), 0);
    chk("R1", "avail", int'(avail_beats), 0);
    chk("R1", "stall", int'(stall), 1);
    chk("R1", "pending", int'(irq_pending), 0);
    chk("R1", "irq", int'(irq), 0);
  endtask

  task automatic t_setup;
    cfg(3'd0, 'h17F);
    cfg(3'd1, 'h300);
    cfg(3'd5, 0);
    chk("R2", "start masked via reinit ptr", int'(wr_ptr), 'h100);
    chk("R3", "reinit ptr", int'(wr_ptr), 'h100);
    chk("R5", "limit behind, avail capped 16", int'(avail_beats), 16);
    cfg(3'd2, 'h140);
    chk("R2", "limit 0x140 masks to ptr -> stall", int'(stall), 1);
    chk("R6", "avail at limit", int'(avail_beats), 0);
  endtask

  task automatic t_limit;
    cfg(3'd2, 'h200);
    chk("R6", "stall released", int'(stall), 0);
    xfer(16);
    chk("R4", "ptr after 16", int'(wr_ptr), 'h180);
    xfer(10);
    chk("R4", "ptr after 10", int'(wr_ptr), 'h1D0);
    chk("R5", "avail capped by limit", int'(avail_beats), 6);
    xfer(6);
    chk("R6", "stall at limit", int'(stall), 1);
    chk("R6", "avail zero at limit", int'(avail_beats), 0);
    cfg(3'd2, 'h100);
    chk("R6", "limit moved, released", int'(stall), 0);
    chk("R5", "limit behind, avail 16", int'(avail_beats), 16);
  endtask

  task automatic t_wrap;
    xfer(16);
    chk("R4", "ptr 0x280", int'(wr_ptr), 'h280);
    xfer(16);
    chk("R4", "wrap to start", int'(wr_ptr), 'h100);
    chk("R6", "wrapped onto limit stalls", int'(stall), 1);
  endtask

  task automatic t_irq;
    cfg(3'd2, 'h280);
    cfg(3'd4, 1);
    cfg(3'd3, 'h10C);
    xfer(1);
    chk("R7", "landing sets pending", int'(irq_pending), 1);
    chk("R9", "irq gated off", int'(irq), 0);
    glb_irq_en = 1'b1;
    #1;
    chk("R9", "irq with global enable", int'(irq), 1);
    cfg(3'd4, 1);
    chk("R8", "ctrl write clears", int'(irq_pending), 0);
    cfg(3'd3, 'h140);
    xfer(16);
    chk("R7", "crossing sets pending", int'(irq_pending), 1);
    cfg(3'd4, 0);
    chk("R8", "disable write clears", int'(irq_pending), 0);
    cfg(3'd3, 'h1C0);
    xfer(16);
    chk("R7", "disabled: no pending", int'(irq_pending), 0);
    chk("R4", "ptr 0x208", int'(wr_ptr), 'h208);
  endtask

  task automatic t_wrap_irq;
    cfg(3'd4, 1);
    cfg(3'd3, 'h100);
    cfg(3'd2, 'h180);
    xfer(16);
    chk("R5", "avail capped by end", int'(avail_beats), 15);
    xfer(15);
    chk("R4", "wrap ptr", int'(wr_ptr), 'h100);
    chk("R7", "wrap onto threshold at start", int'(irq_pending), 1);
  endtask

  task automatic t_priority;
    cfg(3'd3, 'h108);
    cfg(3'd2, 'h200);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = OFS_W'(1);
    xfer_done = 1'b1; xfer_beats = BW'(1);
    @(negedge clk);
    cfg_we = 1'b0; xfer_done = 1'b0;
    chk("R8", "clear wins over hit", int'(irq_pending), 0);
    chk("R4", "ptr advanced", int'(wr_ptr), 'h108);
    cfg(3'd6, 0);
    cfg(3'd7, 'h300);
    chk("R2", "unused code keeps ptr", int'(wr_ptr), 'h108);
    chk("R2", "unused code keeps avail", int'(avail_beats), 16);
    chk("R2", "unused code keeps stall", int'(stall), 0);
  endtask

  task automatic t_reinit_priority;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = '0;
    xfer_done = 1'b1; xfer_beats = BW'(2);
    @(negedge clk);
    cfg_we = 1'b0; xfer_done = 1'b0;
    chk("R3", "reinit wins over completion", int'(wr_ptr), 'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_limit();
    t_wrap();
    t_irq();
    t_wrap_irq();
    t_priority();
    t_reinit_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule